// File: doc/BRIEF.md
# Dual-Edge Interleaved Word Serializer

This block turns a parallel word of 2N bits into a single serial line that carries two bits in every period of a fast clock. It holds two identical N-bit shift lanes. The rise lane takes the even-numbered bits of the word and steps on the rising edge of the fast clock. The fall lane takes the odd-numbered bits and steps on the rising edge of the complementary fast clock. The level of the fast clock then selects which lane drives the line. The result is a double-data-rate stream with the least significant bit first.

A word-rate load strobe is one fast cycle wide and repeats every N fast cycles. It is sampled on the rising edge. The odd half of the word and the strobe are handed across to the falling phase through a small holding stage. The synchronous reset is handed across the same way. Because of this, both lanes always act on the same word, half a period apart. An optional complementary output gives the inverse of the serial line.

Top module: `ddr_word_serializer`

## Requirements
- R1: Word bit 2i is sent from the rise lane during a low half of the fast clock, and word bit 2i+1 is sent from the fall lane during the following high half, for i = 0..N-1.
- R2: After a load is captured at rising edge P, the line carries word bit 0 in the low half that follows P. It then carries bits 1, 2, ... 2N-1 in ascending order, one per half-period, with true polarity (a 1 in the word gives a high line).
- R3: The load strobe and the parallel word are sampled only at rising edges of the fast clock. Loads spaced exactly N cycles apart give a gapless stream. Changes of the word while the strobe is low have no effect on the line.
- R4: Once a word has been shifted out and no new load has come, both lanes fill with zeros and the line stays low.
- R5: A synchronous active-high reset seen at rising edge P clears the rise lane at P and the fall lane at the next falling edge. The line is low from the low half after P until the first word after reset release.
- R6: With the complementary output enabled (INV_EN = 1), ser_out_n is the inverse of ser_out in every half-period. With it disabled, ser_out_n is held low.
- R7: A load that arrives before the previous word has finished replaces the rest of that word. The new word's bit 0 appears in the low half right after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast bit clock; rise lane steps on its rising edge |
| clk_fast_n | input | 1 | Exact complement of clk_fast; fall lane steps on its rising edge |
| rst | input | 1 | Synchronous active-high reset, sampled on clk_fast |
| load | input | 1 | Word-rate load strobe, one fast cycle wide |
| par_in | input | 2*LANE_BITS | Parallel word, bit 0 sent first |
| ser_out | output | 1 | Double-data-rate serial line |
| ser_out_n | output | 1 | Inverse of ser_out, or low when INV_EN = 0 |

## Verification
The assertions assume that clk_fast_n is the exact complement of clk_fast. They also assume that load, rst and par_in change only well away from the rising edge of clk_fast, so that the handoff to the falling phase always sees one settled value. The stimulus meets both assumptions: it generates the two clocks from one variable and changes every input 3 ns after a rising edge. It holds the strobe high for exactly one cycle and scrambles par_in in the cycles where the strobe is low. Reset is held for at least one whole cycle.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;
  typedef enum logic {LANE_RISE = 1'b0, LANE_FALL = 1'b1} lane_e;
endpackage

// File: rtl/ddrser_lane.sv
module ddrser_lane
  import ddrser_pkg::*;
#(
  parameter int    LANE_BITS = 4,
  parameter lane_e LANE      = LANE_RISE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [LANE_BITS-1:0] data,
  output logic                 out_n
);
  logic [LANE_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= data;
    else           sh <= sh >> 1;
  end

  assign out_n = ~sh[0];

  p_clear_r5: assert property (@(posedge clk) rst |=> (sh == '0))
    else $error("lane %s not cleared", LANE.name());
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (sh == $past(data)))
    else $error("lane %s load mismatch", LANE.name());
  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> (sh == ($past(sh) >> 1)))
    else $error("lane %s shift mismatch", LANE.name());
endmodule

// File: rtl/ddrser_handoff.sv
module ddrser_handoff #(
  parameter int LANE_BITS = 4
) (
  input  logic                 clk_fast,
  input  logic                 rst,
  input  logic                 load,
  input  logic [LANE_BITS-1:0] odd_bits,
  output logic                 pend,
  output logic                 rst_fall,
  output logic [LANE_BITS-1:0] hold
);
  always_ff @(posedge clk_fast) begin
    rst_fall <= rst;
    if (rst) begin
      pend <= 1'b0;
      hold <= '0;
    end else begin
      pend <= load;
      if (load) hold <= odd_bits;
    end
  end
endmodule

// File: rtl/ddrser_outsel.sv
module ddrser_outsel #(
  parameter bit INV_EN = 1'b1
) (
  input  logic clk_fast,
  input  logic rise_n,
  input  logic fall_n,
  output logic data,
  output logic data_n
);
  assign data = clk_fast ? ~fall_n : ~rise_n;

  generate
    if (INV_EN) begin : g_inv
      assign data_n = ~data;
    end else begin : g_noinv
      assign data_n = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer
  import ddrser_pkg::*;
#(
  parameter int LANE_BITS = 4,
  parameter bit INV_EN    = 1'b1,
  localparam int WORD_BITS = 2 * LANE_BITS
) (
  input  logic                 clk_fast,
  input  logic                 clk_fast_n,
  input  logic                 rst,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] par_in,
  output logic                 ser_out,
  output logic                 ser_out_n
);
  logic [LANE_BITS-1:0] even_bits, odd_bits, hold;
  logic pend, rst_fall, rise_n, fall_n;

  generate
    for (genvar i = 0; i < LANE_BITS; i++) begin : g_split
      assign even_bits[i] = par_in[2*i];
      assign odd_bits[i]  = par_in[2*i+1];
    end
  endgenerate

  ddrser_lane #(.LANE_BITS(LANE_BITS), .LANE(LANE_RISE)) u_rise (
    .clk(clk_fast), .rst(rst), .load(load), .data(even_bits), .out_n(rise_n)
  );

  ddrser_handoff #(.LANE_BITS(LANE_BITS)) u_handoff (
    .clk_fast(clk_fast), .rst(rst), .load(load), .odd_bits(odd_bits),
    .pend(pend), .rst_fall(rst_fall), .hold(hold)
  );

  ddrser_lane #(.LANE_BITS(LANE_BITS), .LANE(LANE_FALL)) u_fall (
    .clk(clk_fast_n), .rst(rst_fall), .load(pend), .data(hold), .out_n(fall_n)
  );

  ddrser_outsel #(.INV_EN(INV_EN)) u_outsel (
    .clk_fast(clk_fast), .rise_n(rise_n), .fall_n(fall_n),
    .data(ser_out), .data_n(ser_out_n)
  );

  // R1: even bit 0 reaches the rise lane head right after the load edge
  p_even_load_r1: assert property (@(posedge clk_fast) disable iff (rst)
    load |=> (rise_n == ~$past(par_in[0])))
    else $error("rise lane head wrong after load");
  // R1: odd bits handed over reach the fall lane head on the falling phase
  p_odd_load_r1: assert property (@(posedge clk_fast_n) disable iff (rst_fall)
    pend |=> (fall_n == ~$past(hold[0])))
    else $error("fall lane head wrong after handoff");
endmodule

// File: tb/ddr_word_serializer_test.sv
module ddr_word_serializer_test;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic clk_fast = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [W-1:0] par_in = '0;
  logic ser_out, ser_out_n;
  wire  clk_fast_n = ~clk_fast;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R5";
  bit exp_q[$];

  always #4 clk_fast = ~clk_fast;

  ddr_word_serializer #(.LANE_BITS(N), .INV_EN(1'b1)) uut (
    .clk_fast(clk_fast), .clk_fast_n(clk_fast_n), .rst(rst), .load(load),
    .par_in(par_in), .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  // reference: list of half-period values still to appear on the line
  always @(posedge clk_fast) begin
    bit front;
    cycles++;
    front = (exp_q.size() > 0) ? exp_q[0] : 1'b0;
    if (rst || load) begin
      exp_q.delete();
      exp_q.push_back(front);
      if (!rst)
        for (int i = 0; i < W; i++) exp_q.push_back(par_in[i]);
    end
  end

  task automatic sample_half(input bit high);
    bit e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
    if (chk_en) begin
      checks++;
      if (ser_out !== e) begin
        errors++;
        $display("FAIL %s %s half: ser_out actual=%b expected=%b t=%0t",
                 cur_req, high ? "high" : "low", ser_out, e, $time);
      end
      checks++;
      if (ser_out_n !== ~e) begin
        errors++;
        $display("FAIL R6 ser_out_n actual=%b expected=%b t=%0t",
                 ser_out_n, ~e, $time);
      end
    end
  endtask

  always begin
    @(posedge clk_fast); #2; sample_half(1'b1);
    @(negedge clk_fast); #2; sample_half(1'b0);
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk_fast); #3;
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input int gap);
    load = 1'b1;
    par_in = w;
    cyc(1);
    load = 1'b0;
    par_in = W'($urandom);  // R3: ignored while load is low
    cyc(gap - 1);
  endtask

  always @(posedge clk_fast) begin
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    cyc(4);
    chk_en = 1'b1;
    cur_req = "R5";   // reset state: line low in both halves
    cyc(3);
    rst = 1'b0;
    cur_req = "R4";
    cyc(4);

    cur_req = "R2";   // single bits mark the first and last positions
    send_word(8'h01, 2 * N);
    send_word(8'h80, 2 * N);
    cur_req = "R1";   // even-only and odd-only patterns
    send_word(8'h55, 2 * N);
    send_word(8'hAA, 2 * N);

    cur_req = "R3";   // back-to-back words, every N cycles
    for (int k = 0; k < 24; k++) send_word(W'($urandom), N);
    send_word(8'hFF, N);
    send_word(8'h00, N);
    send_word(8'hFF, N);

    cur_req = "R4";   // drained lanes fill with zeros
    cyc(3 * N);

    cur_req = "R7";   // early reloads cut the previous word short
    send_word(8'hF0, 2);
    send_word(8'h3C, 1);
    send_word(8'hC3, 2 * N);

    cur_req = "R5";   // reset in the middle of a word
    send_word(8'hFF, 2);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(N);
    cur_req = "R2";
    send_word(8'hB5, 2 * N);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule